// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a small watchdog peripheral with two byte-wide registers: an 8-bit up-counter and a control/status register. Software reaches them over a simple 16-bit write port and a byte-wide read port. A write only lands when its upper byte carries the unlock code for the target register. The counter code differs from the control code, so a stray or misdirected store cannot reload the counter or stop the timer.

While the run bit is set, the counter advances once per prescaler tick. The prescaler divides the input clock by 32 times a power of two, from 32 up to 4096, picked by a 3-bit code. When the counter wraps from 0xFF to 0x00, the block sets a sticky overflow flag and drives a reset request for a fixed number of clock cycles. Any write whose key is wrong is dropped and reported as a one-cycle pulse on a diagnostic output.

Top module: `kwdt_top`

## Requirements
- R1: A write to address 0 (counter) whose bits [15:8] equal 0x5A loads bits [7:0] into the counter at that clock edge.
- R2: A write to address 1 (control) whose bits [15:8] equal 0xA5 loads bit 7 as the run bit and bits [2:0] as the rate code. Control bits [5:3] always read back as 0.
- R3: A write whose upper byte is not the key of its addressed register changes no register. This includes a write that uses the other register's key. The key-error output is high for exactly the one cycle after such a write.
- R4: The read port returns the 8-bit counter when the read address is 0. When it is 1, it returns the control byte {run, overflow flag, 3'b000, rate code}. The key never appears on the read port.
- R5: After reset the counter, the control byte, the reset request and the key-error output are all 0.
- R6: While run is 1, the counter advances every 2^(5+code) clock cycles. The first step comes 2^(5+code) cycles after the edge that set run. While run is 0, the counter holds its value.
- R7: When a tick finds the counter at 0xFF, the counter becomes 0x00 and the overflow flag (control bit 6) is set. The reset request is then high for 8 cycles, starting in the cycle after that edge.
- R8: A keyed control write with bit 6 at 0 clears the overflow flag. Writing 1 to bit 6 leaves the flag unchanged and never sets it.
- R9: A keyed control write that changes the rate code while run stays 1 restarts the prescaler. The next step then comes a full new period after that write.
- R10: When a keyed counter write and a tick fall on the same edge, the written value wins and no overflow is produced.
- R11: When an overflow and a flag-clearing control write fall on the same edge, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock, also the prescaler source |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Write strobe |
| wr_addr_i | input | 1 | Write target: 0 counter, 1 control |
| wr_data_i | input | 16 | Key in [15:8], payload in [7:0] |
| rd_addr_i | input | 1 | Read select: 0 counter, 1 control |
| rd_data_o | output | 8 | Selected register byte |
| wdt_rst_o | output | 1 | Reset request, high for 8 cycles after a wrap |
| key_err_o | output | 1 | One-cycle pulse after a rejected write |

## Verification
Two collisions matter, and each lands on a single clock edge. The first is a counter reload meeting the tick that would wrap the counter. The second is a wrap meeting a control write that clears the flag. The bench starts the timer with the counter at 0xFF and the fastest rate. From the enabling edge it counts exactly 32 cycles, so the reload or the flag-clearing write lands on the wrap edge. It then judges the result at the ports. For the reload, it checks the loaded value, a quiet reset request, a clear flag, and a single step 32 cycles later. For the flag clear, it checks a set flag and a raised reset request.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

    localparam int unsigned BYTE_W     = 8;
    localparam int unsigned BUS_W      = 2 * BYTE_W;
    localparam int unsigned SEL_W      = 3;
    localparam int unsigned BASE_LOG2  = 5;
    localparam int unsigned NUM_RATES  = 1 << SEL_W;
    localparam int unsigned PRE_W      = BASE_LOG2 + NUM_RATES - 1;
    localparam int unsigned SPARE_W    = BYTE_W - SEL_W - 2;

    typedef enum logic {
        REG_COUNT = 1'b0,
        REG_CTRL  = 1'b1
    } reg_sel_e;

    typedef struct packed {
        logic               run;
        logic               ovf;
        logic [SPARE_W-1:0] spare;
        logic [SEL_W-1:0]   sel;
    } ctrl_t;

    typedef struct packed {
        logic              cnt_wr;
        logic              ctrl_wr;
        logic              bad_key;
        logic [BYTE_W-1:0] payload;
    } wr_req_t;

endpackage

// File: rtl/kwdt_keygate.sv
module kwdt_keygate
    import kwdt_pkg::*;
#(
    parameter logic [BYTE_W-1:0] KEY_COUNT = 8'h5A,
    parameter logic [BYTE_W-1:0] KEY_CTRL  = 8'hA5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en_i,
    input  logic             wr_addr_i,
    input  logic [BUS_W-1:0] wr_data_i,
    output wr_req_t          req_o,
    output logic             key_err_o
);

    typedef struct packed {
        logic err;
    } gate_state_t;

    gate_state_t s_d, s_q;
    logic [BYTE_W-1:0] key_seen;
    logic [BYTE_W-1:0] key_want;
    logic              key_ok;

    always_comb begin
        key_seen = wr_data_i[BUS_W-1:BYTE_W];
        key_want = (wr_addr_i == REG_CTRL) ? KEY_CTRL : KEY_COUNT;
        key_ok   = (key_seen == key_want);

        req_o.cnt_wr  = wr_en_i && key_ok && (wr_addr_i == REG_COUNT);
        req_o.ctrl_wr = wr_en_i && key_ok && (wr_addr_i == REG_CTRL);
        req_o.bad_key = wr_en_i && !key_ok;
        req_o.payload = wr_data_i[BYTE_W-1:0];

        s_d     = s_q;
        s_d.err = req_o.bad_key;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign key_err_o = s_q.err;

    AST_KEY_ERR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        req_o.bad_key |=> key_err_o) else $error("key error not flagged"); // R3

    AST_KEY_ERR_ONLY_BAD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && key_ok) |=> !key_err_o) else $error("key error on good write"); // R3

endmodule

// File: rtl/kwdt_prescaler.sv
module kwdt_prescaler
    import kwdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             restart_i,
    input  logic [SEL_W-1:0] sel_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [PRE_W-1:0] div;
    } pre_state_t;

    pre_state_t       s_d, s_q;
    logic [PRE_W-1:0] limit [NUM_RATES];

    for (genvar g = 0; g < NUM_RATES; g++) begin : g_limit
        assign limit[g] = PRE_W'((64'd1 << (BASE_LOG2 + g)) - 64'd1);
    end

    always_comb begin
        tick_o = run_i && (s_q.div == limit[sel_i]);
        s_d    = s_q;
        if (!run_i || restart_i || tick_o) begin
            s_d.div = '0;
        end else begin
            s_d.div = s_q.div + PRE_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    AST_TICK_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |-> run_i) else $error("tick while stopped"); // R6

    AST_RESTART_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> !tick_o) else $error("tick right after restart"); // R9

endmodule

// File: rtl/kwdt_core.sv
module kwdt_core
    import kwdt_pkg::*;
#(
    parameter int unsigned PULSE_LEN = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wr_req_t           req_i,
    input  logic              tick_i,
    output logic [BYTE_W-1:0] count_o,
    output ctrl_t             ctrl_o,
    output logic              restart_o,
    output logic              rst_o
);

    localparam int unsigned PW = $clog2(PULSE_LEN + 1);

    typedef struct packed {
        logic [BYTE_W-1:0] cnt;
        ctrl_t             ctrl;
        logic [PW-1:0]     pulse;
    } core_state_t;

    core_state_t s_d, s_q;
    logic        wrap;
    logic        new_run;
    logic        new_ovf;
    logic [SEL_W-1:0] new_sel;

    always_comb begin
        s_d       = s_q;
        new_run   = req_i.payload[BYTE_W-1];
        new_ovf   = req_i.payload[BYTE_W-2];
        new_sel   = req_i.payload[SEL_W-1:0];
        restart_o = 1'b0;
        wrap      = tick_i && (s_q.cnt == '1) && !req_i.cnt_wr;

        if (req_i.cnt_wr) begin
            s_d.cnt = req_i.payload;
        end else if (tick_i) begin
            s_d.cnt = s_q.cnt + BYTE_W'(1);
        end

        if (req_i.ctrl_wr) begin
            s_d.ctrl.run   = new_run;
            s_d.ctrl.sel   = new_sel;
            s_d.ctrl.spare = '0;
            s_d.ctrl.ovf   = s_q.ctrl.ovf && new_ovf;
            restart_o      = s_q.ctrl.run && new_run && (new_sel != s_q.ctrl.sel);
        end

        if (wrap) begin
            s_d.ctrl.ovf = 1'b1;
            s_d.pulse    = PW'(PULSE_LEN);
        end else if (s_q.pulse != '0) begin
            s_d.pulse = s_q.pulse - PW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign count_o = s_q.cnt;
    assign ctrl_o  = s_q.ctrl;
    assign rst_o   = (s_q.pulse != '0);

    AST_KEYED_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
        req_i.cnt_wr |=> (count_o == $past(req_i.payload))) else $error("load lost"); // R1

    AST_HOLD_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_o.run && !req_i.cnt_wr) |=> $stable(count_o)) else $error("moved while off"); // R6

    AST_WRAP_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && (count_o == '1) && !req_i.cnt_wr) |=> (ctrl_o.ovf && rst_o && (count_o == '0)))
        else $error("wrap not reported"); // R7

    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_o.ovf && !req_i.ctrl_wr) |=> ctrl_o.ovf) else $error("flag dropped"); // R8

    AST_WRITE_BEATS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i.cnt_wr && tick_i && !ctrl_o.ovf && !req_i.ctrl_wr) |=> !ctrl_o.ovf)
        else $error("overflow despite reload"); // R10

    AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        req_i.ctrl_wr |=> (ctrl_o.spare == '0)) else $error("spare bits stored"); // R2

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top
    import kwdt_pkg::*;
#(
    parameter logic [7:0]  KEY_COUNT = 8'h5A,
    parameter logic [7:0]  KEY_CTRL  = 8'hA5,
    parameter int unsigned PULSE_LEN = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en_i,
    input  logic        wr_addr_i,
    input  logic [15:0] wr_data_i,
    input  logic        rd_addr_i,
    output logic [7:0]  rd_data_o,
    output logic        wdt_rst_o,
    output logic        key_err_o
);

    wr_req_t           req;
    logic              tick;
    logic              restart;
    logic [BYTE_W-1:0] count;
    ctrl_t             ctrl;

    kwdt_keygate #(
        .KEY_COUNT (KEY_COUNT),
        .KEY_CTRL  (KEY_CTRL)
    ) u_gate (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .req_o     (req),
        .key_err_o (key_err_o)
    );

    kwdt_prescaler u_pre (
        .clk       (clk),
        .rst_n     (rst_n),
        .run_i     (ctrl.run),
        .restart_i (restart),
        .sel_i     (ctrl.sel),
        .tick_o    (tick)
    );

    kwdt_core #(
        .PULSE_LEN (PULSE_LEN)
    ) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_i     (req),
        .tick_i    (tick),
        .count_o   (count),
        .ctrl_o    (ctrl),
        .restart_o (restart),
        .rst_o     (wdt_rst_o)
    );

    always_comb begin
        rd_data_o = (rd_addr_i == REG_CTRL) ? ctrl : count;
    end

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.run && !wdt_rst_o) |=> !wdt_rst_o) else $error("reset request while idle"); // R7

endmodule

// File: tb/tb_kwdt_top.sv
module tb_kwdt_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en_i = 1'b0;
    logic        wr_addr_i = 1'b0;
    logic [15:0] wr_data_i = '0;
    logic        rd_addr_i = 1'b0;
    logic [7:0]  rd_data_o;
    logic        wdt_rst_o;
    logic        key_err_o;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    kwdt_top dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (wr_en_i),
        .wr_addr_i (wr_addr_i),
        .wr_data_i (wr_data_i),
        .rd_addr_i (rd_addr_i),
        .rd_data_o (rd_data_o),
        .wdt_rst_o (wdt_rst_o),
        .key_err_o (key_err_o)
    );

    task automatic chk(input string req, input string what, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %02h expected %02h", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [15:0] d);
        wr_en_i   = 1'b1;
        wr_addr_i = a;
        wr_data_i = d;
        @(negedge clk);
        wr_en_i   = 1'b0;
        wr_data_i = '0;
    endtask

    task automatic rd(input logic a, output logic [7:0] v);
        rd_addr_i = a;
        #1;
        v = rd_data_o;
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic finish_run;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [7:0] v;
        int r;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R5 reset state
        rd(1'b0, v); chk("R5", "counter", v, 8'h00);
        rd(1'b1, v); chk("R5", "control", v, 8'h00);
        chk("R5", "reset req", {7'd0, wdt_rst_o}, 8'h00);
        chk("R5", "key err", {7'd0, key_err_o}, 8'h00);

        // R3 wrong keys while idle
        wr(1'b0, 16'h5B12);
        chk("R3", "key err pulse", {7'd0, key_err_o}, 8'h01);
        rd(1'b0, v); chk("R3", "counter kept", v, 8'h00);
        @(negedge clk);
        chk("R3", "key err one cycle", {7'd0, key_err_o}, 8'h00);
        wr(1'b1, 16'h5A87);
        chk("R3", "cross key pulse", {7'd0, key_err_o}, 8'h01);
        rd(1'b1, v); chk("R3", "control kept", v, 8'h00);
        wr(1'b0, 16'hA533);
        rd(1'b0, v); chk("R3", "counter cross key", v, 8'h00);

        // R1 / R4 keyed load, R6 holds while off
        wr(1'b0, 16'h5A37);
        chk("R1", "no key err", {7'd0, key_err_o}, 8'h00);
        rd(1'b0, v); chk("R1", "counter loaded", v, 8'h37);
        wait_n(100);
        rd(1'b0, v); chk("R6", "hold while off", v, 8'h37);

        // R2 spare bits read 0
        wr(1'b1, 16'hA53D);
        rd(1'b1, v); chk("R2", "spare masked", v, 8'h05);
        wr(1'b1, 16'hA500);

        // R6 / R7 sweep of all rate codes
        for (int s = 0; s < 8; s++) begin
            r = 32 << s;
            wr(1'b1, 16'hA500);
            wr(1'b0, 16'h5AFD);
            wr(1'b1, 16'hA580 | 16'(s));
            wait_n(r - 1);
            rd(1'b0, v); chk("R6", "before first step", v, 8'hFD);
            wait_n(1);
            rd(1'b0, v); chk("R6", "first step", v, 8'hFE);
            wait_n(2 * r - 1);
            rd(1'b0, v); chk("R7", "before wrap", v, 8'hFF);
            chk("R7", "no req before wrap", {7'd0, wdt_rst_o}, 8'h00);
            wait_n(1);
            rd(1'b0, v); chk("R7", "wrapped", v, 8'h00);
            rd(1'b1, v); chk("R7", "flag set", v, 8'hC0 | 8'(s));
            chk("R7", "req rises", {7'd0, wdt_rst_o}, 8'h01);
            wait_n(7);
            chk("R7", "req held", {7'd0, wdt_rst_o}, 8'h01);
            wait_n(1);
            chk("R7", "req ends", {7'd0, wdt_rst_o}, 8'h00);
        end

        // R8 flag clear semantics (running, code 7, flag set)
        wr(1'b1, 16'hA5C7);
        rd(1'b1, v); chk("R8", "write one keeps", v, 8'hC7);
        wr(1'b1, 16'hA587);
        rd(1'b1, v); chk("R8", "write zero clears", v, 8'h87);
        wr(1'b1, 16'hA5C7);
        rd(1'b1, v); chk("R8", "write one no set", v, 8'h87);

        // R9 rate change restarts prescaler
        wr(1'b1, 16'hA500);
        wr(1'b0, 16'h5AFF);
        wr(1'b1, 16'hA587);
        wait_n(100);
        wr(1'b1, 16'hA580);
        wait_n(31);
        rd(1'b0, v); chk("R9", "no step yet", v, 8'hFF);
        chk("R9", "no req yet", {7'd0, wdt_rst_o}, 8'h00);
        wait_n(1);
        rd(1'b0, v); chk("R9", "step after new period", v, 8'h00);
        chk("R9", "req after new period", {7'd0, wdt_rst_o}, 8'h01);

        // R3 wrong key while running leaves control alone
        wr(1'b1, 16'hA400);
        chk("R3", "running key err", {7'd0, key_err_o}, 8'h01);
        rd(1'b1, v); chk("R3", "running control kept", v, 8'hC0);

        // R11 overflow and flag clear on one edge
        wr(1'b1, 16'hA500);
        wr(1'b0, 16'h5AFF);
        wait_n(10);
        wr(1'b1, 16'hA580);
        wait_n(31);
        wr(1'b1, 16'hA580);
        rd(1'b1, v); chk("R11", "flag wins", v, 8'hC0);
        chk("R11", "req raised", {7'd0, wdt_rst_o}, 8'h01);

        // R10 reload and wrap tick on one edge
        wr(1'b1, 16'hA500);
        wr(1'b0, 16'h5AFF);
        wait_n(10);
        wr(1'b1, 16'hA580);
        wait_n(31);
        wr(1'b0, 16'h5A10);
        rd(1'b0, v); chk("R10", "reload wins", v, 8'h10);
        rd(1'b1, v); chk("R10", "no flag", v, 8'h80);
        chk("R10", "no req", {7'd0, wdt_rst_o}, 8'h00);
        wait_n(31);
        rd(1'b0, v); chk("R10", "held until tick", v, 8'h10);
        wait_n(1);
        rd(1'b0, v); chk("R10", "next tick steps", v, 8'h11);

        finish_run();
    end

endmodule